// File: doc/BRIEF.md
# Register Write-Protection Guard

This block stands between a simple register write bus and a bank of I/O configuration registers. It decides, write by write, whether the bank may see the strobe. When protection is enabled, writes aimed at any of a fixed set of configuration offsets are dropped in the same cycle. The guard then keeps a sticky record that a write was refused, together with the offset that write targeted.

Software controls the guard through two registers of its own. The control register holds the protection enable bit. It changes only on a write whose upper 24 bits carry a fixed key, and such a keyed write also wipes the violation record. The status register is read-only and reports the flag and the recorded offset. Reads are combinational, come from a separate read address, and have no side effects. The bank's own registers and any interrupt signalling are outside this block.

Top module: `wrprot_guard`

## Requirements
- R1: After reset, protection is disabled, the violation flag is clear and the recorded offset is zero. Both guard registers therefore read as 0.
- R2: While protection is enabled, a write to a protected offset does not reach the bank: `bank_wr` stays low in the cycle of the write.
- R3: A write passes to the bank unchanged in the same cycle, and leaves the violation record untouched, if it targets an unprotected offset that the guard does not own, or if protection is disabled.
- R4: A refused write sets the violation flag and stores the write's 16-bit offset in the source field from the next cycle on.
- R5: Each later refused write overwrites the stored offset, and the flag stays set.
- R6: A write to the control register at offset 0x0E4 carrying the key 0xC3A55A in bits [31:8] loads the enable from bit 0 and clears the flag and the stored offset.
- R7: A write to the control register with any other key is ignored: the enable, the flag and the offset all stay as they were.
- R8: Reading the status register at offset 0x0E8 returns the flag in bit 0 and the offset in bits [23:8], with zeros elsewhere. Reading the control register returns the enable in bit 0. Reading never changes either value.
- R9: Writes to the control and status offsets are never forwarded to the bank, and a write to the status register changes nothing.
- R10: The protected offsets are 0x000, 0x004, 0x010, 0x014, 0x020, 0x024, 0x050, 0x054, 0x060, 0x064, 0x070, 0x074, 0x090, 0x094, 0x0A0, 0x0A4 and 0x150. Each one is refused and recorded while protection is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe from the bus |
| bus_addr | input | ADDR_W | Write byte offset |
| bus_wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data for the guard's own registers, zero for any other offset |
| bank_wr | output | 1 | Write strobe forwarded to the register bank |
| bank_addr | output | ADDR_W | Write offset forwarded to the bank |
| bank_wdata | output | DATA_W | Write data forwarded to the bank |

## Verification
The bench sends a control write with the wrong key but a set enable bit. A design that checked only the enable bit would turn protection on there, or would clear a pending violation. It sends two refused writes in a row to check that the second offset replaces the first while the flag stays set. A design that latched only the first offset would keep reporting a stale source. Every protected offset is tried, and so is a close unprotected neighbour, so a missing or extra comparator in the decode shows up as a forwarded or wrongly recorded write. Writes to the status register and refused writes are each followed by a read, which would expose a guard that leaked such a write into its record or into the bank.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam int N_PROT = 17;
   localparam int OFF_W  = 16;

   // configuration offsets guarded against writes while protection is on
   localparam logic [OFF_W-1:0] PROT_OFFS [0:N_PROT-1] = '{
      16'h0000, 16'h0004,   // pin control enable/disable
      16'h0010, 16'h0014,   // output driver enable/disable
      16'h0020, 16'h0024,   // glitch filter enable/disable
      16'h0050, 16'h0054,   // open-drain enable/disable
      16'h0060, 16'h0064,   // pull-up disable/enable
      16'h0070, 16'h0074,   // peripheral select words
      16'h0090, 16'h0094,   // pull-down disable/enable
      16'h00A0, 16'h00A4,   // direct output write enable/disable
      16'h0150              // capture mode
   };

   localparam logic [OFF_W-1:0] CTRL_OFF = 16'h00E4;
   localparam logic [OFF_W-1:0] STAT_OFF = 16'h00E8;
   localparam logic [23:0]      DEF_KEY  = 24'hC3A55A;
endpackage

// File: rtl/wpg_addr_match.sv
module wpg_addr_match
   import wpg_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LSB_IGNORE = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              prot_hit,
   output logic              ctrl_hit,
   output logic              stat_hit
);
   localparam int CMP_LO = LSB_IGNORE;

   initial begin
      if (LSB_IGNORE < 0 || LSB_IGNORE > 2)
         $error("wpg_addr_match: LSB_IGNORE must be 0..2");
   end

   logic [N_PROT-1:0] hit_vec;

   generate
      for (genvar i = 0; i < N_PROT; i++) begin : g_cmp
         localparam logic [ADDR_W-1:0] OFF_I = ADDR_W'(PROT_OFFS[i]);
         if (CMP_LO == 0) begin : g_full
            assign hit_vec[i] = (addr == OFF_I);
         end else begin : g_word
            assign hit_vec[i] = (addr[ADDR_W-1:CMP_LO] == OFF_I[ADDR_W-1:CMP_LO]);
         end
      end

      if (CMP_LO == 0) begin : g_own_full
         assign ctrl_hit = (addr == ADDR_W'(CTRL_OFF));
         assign stat_hit = (addr == ADDR_W'(STAT_OFF));
      end else begin : g_own_word
         localparam logic [ADDR_W-1:0] C_O = ADDR_W'(CTRL_OFF);
         localparam logic [ADDR_W-1:0] S_O = ADDR_W'(STAT_OFF);
         assign ctrl_hit = (addr[ADDR_W-1:CMP_LO] == C_O[ADDR_W-1:CMP_LO]);
         assign stat_hit = (addr[ADDR_W-1:CMP_LO] == S_O[ADDR_W-1:CMP_LO]);
      end
   endgenerate

   assign prot_hit = |hit_vec;

   always_comb begin
      assert_onehot_R10: assert ($onehot0(hit_vec) || $isunknown(addr))
         else $error("protected offsets overlap");
   end
endmodule

// File: rtl/wpg_mode_ctl.sv
module wpg_mode_ctl #(
   parameter int          DATA_W = 32,
   parameter logic [23:0] KEY    = 24'hC3A55A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              ctrl_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              prot_en,
   output logic              key_wr
);
   initial begin
      if (DATA_W < 32) $error("wpg_mode_ctl: DATA_W must be at least 32");
   end

   logic key_ok;
   assign key_ok = (wdata[8 +: 24] == KEY);
   assign key_wr = wr && ctrl_hit && key_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prot_en <= 1'b0;
      else if (key_wr) prot_en <= wdata[0];
   end

   assert_badkey_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ctrl_hit && !key_ok) |=> $stable(prot_en));

   assert_keyload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (prot_en == $past(wdata[0])));
endmodule

// File: rtl/wpg_viol_rec.sv
module wpg_viol_rec #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr,
   output logic              flag,
   output logic [ADDR_W-1:0] src
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (blocked) begin
         flag <= 1'b1;
         src  <= addr;
      end else if (clr) begin
         flag <= 1'b0;
         src  <= '0;
      end
   end

   assert_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (flag && src == $past(addr)));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !blocked) |=> (!flag && src == '0));
endmodule

// File: rtl/wrprot_guard.sv
module wrprot_guard
   import wpg_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 32,
   parameter int          LSB_IGNORE = 2,
   parameter logic [23:0] KEY        = DEF_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              bank_wr,
   output logic [ADDR_W-1:0] bank_addr,
   output logic [DATA_W-1:0] bank_wdata
);
   localparam int SRC_LSB = 8;

   initial begin
      if (ADDR_W < 9 || ADDR_W > OFF_W) $error("wrprot_guard: ADDR_W must be 9..16");
      if (DATA_W < SRC_LSB + ADDR_W)     $error("wrprot_guard: DATA_W too narrow");
   end

   logic prot_hit, ctrl_hit, stat_hit;
   logic r_prot, r_ctrl, r_stat;
   logic prot_en, key_wr, blocked, flag;
   logic [ADDR_W-1:0] src;

   wpg_addr_match #(.ADDR_W(ADDR_W), .LSB_IGNORE(LSB_IGNORE)) u_wmatch (
      .addr(bus_addr), .prot_hit(prot_hit), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit)
   );

   wpg_addr_match #(.ADDR_W(ADDR_W), .LSB_IGNORE(LSB_IGNORE)) u_rmatch (
      .addr(rd_addr), .prot_hit(r_prot), .ctrl_hit(r_ctrl), .stat_hit(r_stat)
   );

   wpg_mode_ctl #(.DATA_W(DATA_W), .KEY(KEY)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .ctrl_hit(ctrl_hit),
      .wdata(bus_wdata), .prot_en(prot_en), .key_wr(key_wr)
   );

   assign blocked = bus_wr && prot_en && prot_hit;

   wpg_viol_rec #(.ADDR_W(ADDR_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .blocked(blocked), .addr(bus_addr),
      .clr(key_wr), .flag(flag), .src(src)
   );

   assign bank_wr    = bus_wr && !blocked && !ctrl_hit && !stat_hit;
   assign bank_addr  = bus_addr;
   assign bank_wdata = bus_wdata;

   always_comb begin
      rd_data = '0;
      if (r_stat) begin
         rd_data[0]                  = flag;
         rd_data[SRC_LSB +: ADDR_W]  = src;
      end else if (r_ctrl) begin
         rd_data[0] = prot_en;
      end
   end

   logic unused_rprot;
   assign unused_rprot = r_prot;

   assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && prot_en && prot_hit) |-> !bank_wr);

   assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !prot_en && !ctrl_hit && !stat_hit) |-> bank_wr);

   assert_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (ctrl_hit || stat_hit)) |-> !bank_wr);

   assert_statwr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && stat_hit) |=> ($stable(flag) && $stable(src)));
endmodule

// File: tb/sim_wrprot_guard.sv
module sim_wrprot_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [15:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        bank_wr;
   logic [15:0] bank_addr;
   logic [31:0] bank_wdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [15:0] CTRL = 16'h00E4;
   localparam logic [15:0] STAT = 16'h00E8;
   localparam logic [23:0] GOOD = 24'hC3A55A;
   localparam logic [15:0] PLIST [0:16] = '{
      16'h000, 16'h004, 16'h010, 16'h014, 16'h020, 16'h024, 16'h050, 16'h054,
      16'h060, 16'h064, 16'h070, 16'h074, 16'h090, 16'h094, 16'h0A0, 16'h0A4,
      16'h150
   };

   always #5 clk = ~clk;

   wrprot_guard u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .bank_wr(bank_wr), .bank_addr(bank_addr), .bank_wdata(bank_wdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one write cycle; the forwarded strobe is sampled mid-cycle
   task automatic wr(input logic [15:0] a, input logic [31:0] d,
                     input logic exp_bank, input string tag);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1 chk(tag, {31'b0, bank_wr}, {31'b0, exp_bank});
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr = a;
      #1 chk(tag, rd_data, exp);
   endtask

   function automatic logic [31:0] stat_val(input logic f, input logic [15:0] off);
      return {8'b0, off, 7'b0, f};
   endfunction

   task automatic t_reset();
      rd(STAT, 32'h0, "R1 status after reset");
      rd(CTRL, 32'h0, "R1 control after reset");
   endtask

   task automatic t_disabled_pass();
      wr(16'h010, 32'hAAAA_5555, 1'b1, "R3 protected offset passes while disabled");
      rd(STAT, 32'h0, "R3 no violation while disabled");
   endtask

   task automatic t_bad_key_enable();
      wr(CTRL, {24'h123456, 8'h01}, 1'b0, "R9 control write not forwarded");
      rd(CTRL, 32'h0, "R7 wrong key leaves protection off");
   endtask

   task automatic t_enable();
      wr(CTRL, {GOOD, 8'h01}, 1'b0, "R9 keyed control write not forwarded");
      rd(CTRL, 32'h1, "R6 keyed write enables protection");
   endtask

   task automatic t_unprot();
      wr(16'h0C0, 32'h1, 1'b1, "R3 unprotected offset passes while enabled");
      wr(16'h008, 32'h1, 1'b1, "R3 neighbour offset passes while enabled");
      rd(STAT, 32'h0, "R3 unprotected writes record nothing");
   endtask

   task automatic t_block();
      wr(16'h024, 32'hFFFF_FFFF, 1'b0, "R2 protected write dropped");
      rd(STAT, stat_val(1'b1, 16'h024), "R4 violation flag and offset");
      rd(STAT, stat_val(1'b1, 16'h024), "R8 repeated read unchanged");
   endtask

   task automatic t_overwrite();
      wr(16'h150, 32'h0, 1'b0, "R2 capture mode write dropped");
      rd(STAT, stat_val(1'b1, 16'h150), "R5 later offset overwrites, flag stays");
   endtask

   task automatic t_bad_key_clear();
      wr(CTRL, {GOOD ^ 24'h000001, 8'h00}, 1'b0, "R9 bad-key write not forwarded");
      rd(STAT, stat_val(1'b1, 16'h150), "R7 wrong key keeps violation");
      rd(CTRL, 32'h1, "R7 wrong key keeps enable");
   endtask

   task automatic t_stat_write();
      wr(STAT, 32'h0, 1'b0, "R9 status write not forwarded");
      rd(STAT, stat_val(1'b1, 16'h150), "R9 status write has no effect");
   endtask

   task automatic t_clear();
      wr(CTRL, {GOOD, 8'h01}, 1'b0, "R6 keyed write not forwarded");
      rd(STAT, 32'h0, "R6 keyed write clears record");
      rd(CTRL, 32'h1, "R6 enable reloaded as 1");
   endtask

   task automatic t_all_offsets();
      for (int i = 0; i < 17; i++) begin
         wr(PLIST[i], 32'h0, 1'b0, $sformatf("R10 offset %h dropped", PLIST[i]));
         rd(STAT, stat_val(1'b1, PLIST[i]), $sformatf("R10 offset %h recorded", PLIST[i]));
      end
   endtask

   task automatic t_disable();
      wr(CTRL, {GOOD, 8'h00}, 1'b0, "R6 keyed disable not forwarded");
      rd(CTRL, 32'h0, "R6 protection disabled");
      rd(STAT, 32'h0, "R6 disable also clears record");
      wr(16'h0A4, 32'h3, 1'b1, "R3 protected offset passes after disable");
      rd(STAT, 32'h0, "R3 no record after disable");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_disabled_pass();
      t_bad_key_enable();
      t_enable();
      t_unprot();
      t_block();
      t_overwrite();
      t_bad_key_clear();
      t_stat_write();
      t_clear();
      t_all_offsets();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule